// File: doc/BRIEF.md
# Entropy Source Register Front End

This block is the register-mapped face of a hardware random number generator. A 32-bit single-cycle register bus reaches five registers: control, status, output data, noise-source settings and health-test settings. Random words come in from an external entropy source on a valid/ready stream, pass through a short first-in first-out pipeline, and are read one at a time from the data register. The source also has a fault strobe. A pulse on it stands for a failed seed, so a testbench can inject seed errors at any point.

Configuration is loaded through a conditional-reset handshake. Software writes the control register with the reset bit set, and the configuration fields in that same write are applied. Software then writes the bit back to zero. The block keeps the bit reading one until a fixed internal reset interval has passed. A seed error stops generation and sets a current flag and a latched flag. Recovery comes either from the conditional-reset handshake or, when `auto_recover` is high, from a self-timed reset that leaves the latched flag set for software to see. Words that were queued before the error can never be read out: while the current seed-error flag is set, the data register returns zero.

Stream rules: the source holds `ent_data` stable and keeps `ent_valid` high until a cycle in which `ent_ready` is also high. A word transfers on every rising clock edge where both are high. `ent_ready` does not depend on `ent_valid`. It is high only when generation is enabled, no seed error is pending, no conditional reset is in progress, the pipeline has room, and the rate divider allows a transfer in that cycle. Back-pressure is applied by holding `ent_ready` low.

Top module: `entropy_csr`

## Requirements
- R1: After reset, the control, status, data, noise and health-test registers all read zero, and `ent_ready` is low.
- R2: The registers sit at byte offsets 0x00 control, 0x04 status, 0x08 data, 0x0C noise settings and 0x10 health-test settings. Any other offset reads zero, and writes to it change nothing.
- R3: Control bit 2 (enable) takes the value of every control write. The configuration fields are bit 5 (clock-error detect), bits 19:16 (divider exponent), bits 15:8 and bits 25:20. They change only on a control write that has bit 30 set; any other control write leaves them unchanged.
- R4: Control bit 30 reads 1 from the write that sets it, through the write that clears it, and for RESET_CYC more cycles after that. It then reads 0, the seed-error current flag is cleared and the pipeline is empty. The noise and health-test registers accept writes only while bit 30 reads 1.
- R5: Control bit 31 (lock) stays set once set, until hardware reset. A write that sets it also loads the configuration carried in that same write. While it is set, the configuration fields, the noise register and the health-test register ignore writes.
- R6: The noise register keeps bits 17:0, and bits 31:18 read zero.
- R7: A word transfers only when `ent_valid` and `ent_ready` are both high. `ent_ready` is low while enable is 0, while a seed error is pending, while bit 30 reads 1, or while the pipeline holds DEPTH words.
- R8: With divider exponent n, accepted words are at least 2^n cycles apart. A source that is always valid gets exactly one word every 2^n cycles.
- R9: Data reads return words oldest first and remove them. Status bit 0 is 1 exactly while the pipeline holds a word, and it reads 0 in the cycle after the last word is read.
- R10: A fault pulse while enabled and not in conditional reset sets status bit 2 (current) and bit 6 (latched) in the next cycle. While bit 2 is 1, data reads return zero. A fault while disabled has no effect.
- R11: With `auto_recover` high, status bit 2 clears RECOVER_CYC cycles after the fault, bit 6 stays set, and the pipeline is emptied. With it low, bit 2 stays set until a conditional reset completes.
- R12: Status bits 5 and 6 are cleared by a status write that has 0 in that bit, and kept by a write that has 1 there. A status write does not change status bits 0, 1 and 2.
- R13: With control bit 5 set, a high `clk_slow` sets status bit 1 while it lasts and latches bit 5. With bit 5 clear, `clk_slow` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| ent_valid | input | 1 | Entropy word offered |
| ent_ready | output | 1 | Entropy word can be taken this cycle |
| ent_data | input | 32 | Entropy word |
| ent_fault | input | 1 | Seed-error strobe from the source |
| clk_slow | input | 1 | Generator clock too slow indication |
| auto_recover | input | 1 | Select self-timed recovery from seed errors |

## Verification
Two things can land on the same clock edge: a data-register read that removes the oldest word, and a stream handshake that adds a new one. The bench sets up a pipeline holding one word with the divider at 1. It then drives a data read together with a valid word in the same cycle. The read must return the older word, and the pipeline must still show exactly one word, which reads back as the newer one. A second overlap is a fault pulse while words are queued. The next data read must return zero even though status bit 0 still reports a word.

// File: rtl/entropy_csr_pkg.sv
package entropy_csr_pkg;
  // register byte offsets
  localparam int OFF_CTRL  = 0;
  localparam int OFF_STAT  = 4;
  localparam int OFF_DATA  = 8;
  localparam int OFF_NOISE = 12;
  localparam int OFF_HTEST = 16;

  // control bit positions
  localparam int CB_EN    = 2;
  localparam int CB_CED   = 5;
  localparam int CB_LO    = 8;
  localparam int CB_DIV   = 16;
  localparam int CB_HI    = 20;
  localparam int CB_COND  = 30;
  localparam int CB_LOCK  = 31;
  localparam int CFG_LO_W = 8;
  localparam int CFG_HI_W = 6;
  localparam int DIV_W    = 4;

  // status bit positions
  localparam int SB_DRDY = 0;
  localparam int SB_CECS = 1;
  localparam int SB_SECS = 2;
  localparam int SB_CEIS = 5;
  localparam int SB_SEIS = 6;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_HOLD = 2'd1,
    CS_BUSY = 2'd2
  } cond_state_e;
endpackage

// File: rtl/entropy_pipe.sv
module entropy_pipe #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/entropy_pacer.sv
module entropy_pacer #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int CW = (1 << EXP_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  // mask of the low exp_sel bits; exp_sel = CW wraps to all ones
  assign mask = (CW'(1) << exp_sel) - CW'(1);
  assign tick = ((cnt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/entropy_seed_ctl.sv
module entropy_seed_ctl
  import entropy_csr_pkg::*;
#(
  parameter int RESET_CYC   = 16,
  parameter int RECOVER_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic auto_recover,
  input  logic cond_set,
  input  logic cond_clear,
  output logic cond_busy,
  output logic seed_err,
  output logic flush
);
  localparam int MAXC  = (RESET_CYC > RECOVER_CYC) ? RESET_CYC : RECOVER_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  cond_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rec_cnt;
  logic             rec_fire;

  assign cond_busy = (state != CS_IDLE);
  assign rec_fire  = seed_err & auto_recover & (state == CS_IDLE) &
                     (rec_cnt == '0) & ~fault;
  assign flush     = cond_busy | rec_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CS_IDLE;
      cnt      <= '0;
      rec_cnt  <= '0;
      seed_err <= 1'b0;
    end else begin
      case (state)
        CS_IDLE: if (cond_set) state <= CS_HOLD;
        CS_HOLD: if (cond_clear) begin
          state <= CS_BUSY;
          cnt   <= CNT_W'(RESET_CYC - 1);
        end
        CS_BUSY: begin
          if (cond_set) begin
            state <= CS_HOLD;
          end else if (cnt == '0) begin
            state    <= CS_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= CS_IDLE;
      endcase

      if (fault) begin
        seed_err <= 1'b1;
        rec_cnt  <= CNT_W'(RECOVER_CYC - 1);
      end else if (state == CS_BUSY && cnt == '0 && !cond_set) begin
        seed_err <= 1'b0;
      end else if (rec_fire) begin
        seed_err <= 1'b0;
      end else if (seed_err && auto_recover && state == CS_IDLE) begin
        rec_cnt <= rec_cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/entropy_csr.sv
module entropy_csr
  import entropy_csr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DEPTH       = 4,
  parameter int NOISE_W     = 18,
  parameter int RESET_CYC   = 16,
  parameter int RECOVER_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ent_valid,
  output logic              ent_ready,
  input  logic [31:0]       ent_data,
  input  logic              ent_fault,
  input  logic              clk_slow,
  input  logic              auto_recover
);
  localparam int DATA_W = 32;

  // register state
  logic                en_q, lock_q, ced_q;
  logic [DIV_W-1:0]    div_q;
  logic [CFG_LO_W-1:0] cfg_lo_q;
  logic [CFG_HI_W-1:0] cfg_hi_q;
  logic [NOISE_W-1:0]  nscr_q;
  logic [DATA_W-1:0]   htcr_q;
  logic                cecs_q, ceis_q, sei_q;

  // decode
  logic rd_req, wr_req;
  logic hit_ctrl, hit_stat, hit_data, hit_noise, hit_htest;
  logic wr_ctrl, wr_stat, wr_noise, wr_htest, rd_data;
  logic cond_set, cond_clear, cfg_take;

  assign rd_req    = bus_en & ~bus_we;
  assign wr_req    = bus_en & bus_we;
  assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat  = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_data  = (bus_addr == ADDR_W'(OFF_DATA));
  assign hit_noise = (bus_addr == ADDR_W'(OFF_NOISE));
  assign hit_htest = (bus_addr == ADDR_W'(OFF_HTEST));
  assign wr_ctrl   = wr_req & hit_ctrl;
  assign wr_stat   = wr_req & hit_stat;
  assign wr_noise  = wr_req & hit_noise;
  assign wr_htest  = wr_req & hit_htest;
  assign rd_data   = rd_req & hit_data;
  assign cond_set   = wr_ctrl & bus_wdata[CB_COND];
  assign cond_clear = wr_ctrl & ~bus_wdata[CB_COND];
  assign cfg_take   = cond_set & ~lock_q;

  logic wdata_unused;
  assign wdata_unused = ^bus_wdata;

  // seed error and conditional reset sequencing
  logic cond_busy, seed_err, flush, fault_evt;
  assign fault_evt = ent_fault & en_q & ~cond_busy;

  entropy_seed_ctl #(
    .RESET_CYC  (RESET_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) u_seed (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault       (fault_evt),
    .auto_recover(auto_recover),
    .cond_set    (cond_set),
    .cond_clear  (cond_clear),
    .cond_busy   (cond_busy),
    .seed_err    (seed_err),
    .flush       (flush)
  );

  // rate divider
  logic tick;
  entropy_pacer #(.EXP_W(DIV_W)) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .exp_sel(div_q),
    .tick   (tick)
  );

  // output pipeline
  logic [DATA_W-1:0] head;
  logic              empty, full, push, pop;

  assign ent_ready = en_q & ~seed_err & ~cond_busy & ~full & tick;
  assign push      = ent_valid & ent_ready;
  assign pop       = rd_data & ~empty;

  entropy_pipe #(.W(DATA_W), .DEPTH(DEPTH)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .din  (ent_data),
    .pop  (pop),
    .flush(flush),
    .head (head),
    .empty(empty),
    .full (full)
  );

  // register updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      lock_q   <= 1'b0;
      ced_q    <= 1'b0;
      div_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      nscr_q   <= '0;
      htcr_q   <= '0;
      cecs_q   <= 1'b0;
      ceis_q   <= 1'b0;
      sei_q    <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[CB_EN];
      if (wr_ctrl && bus_wdata[CB_LOCK]) lock_q <= 1'b1;
      if (cfg_take) begin
        ced_q    <= bus_wdata[CB_CED];
        div_q    <= bus_wdata[CB_DIV +: DIV_W];
        cfg_lo_q <= bus_wdata[CB_LO +: CFG_LO_W];
        cfg_hi_q <= bus_wdata[CB_HI +: CFG_HI_W];
      end
      if (wr_noise && cond_busy && !lock_q) nscr_q <= bus_wdata[NOISE_W-1:0];
      if (wr_htest && cond_busy && !lock_q) htcr_q <= bus_wdata;

      cecs_q <= clk_slow & ced_q;
      if (clk_slow && ced_q)                  ceis_q <= 1'b1;
      else if (wr_stat && !bus_wdata[SB_CEIS]) ceis_q <= 1'b0;

      if (fault_evt)                           sei_q <= 1'b1;
      else if (wr_stat && !bus_wdata[SB_SEIS]) sei_q <= 1'b0;
    end
  end

  // read view
  logic [DATA_W-1:0] ctrl_word, stat_word, data_word;

  always_comb begin
    ctrl_word                       = '0;
    ctrl_word[CB_EN]                = en_q;
    ctrl_word[CB_CED]               = ced_q;
    ctrl_word[CB_LO +: CFG_LO_W]    = cfg_lo_q;
    ctrl_word[CB_DIV +: DIV_W]      = div_q;
    ctrl_word[CB_HI +: CFG_HI_W]    = cfg_hi_q;
    ctrl_word[CB_COND]              = cond_busy;
    ctrl_word[CB_LOCK]              = lock_q;

    stat_word          = '0;
    stat_word[SB_DRDY] = ~empty;
    stat_word[SB_CECS] = cecs_q;
    stat_word[SB_SECS] = seed_err;
    stat_word[SB_CEIS] = ceis_q;
    stat_word[SB_SEIS] = sei_q;

    data_word = (seed_err | empty) ? '0 : head;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      if (hit_ctrl)       bus_rdata = ctrl_word;
      else if (hit_stat)  bus_rdata = stat_word;
      else if (hit_data)  bus_rdata = data_word;
      else if (hit_noise) bus_rdata = DATA_W'(nscr_q);
      else if (hit_htest) bus_rdata = htcr_q;
    end
  end
endmodule

// File: rtl/entropy_csr_chk.sv
module entropy_csr_chk #(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ent_valid,
  input logic              ent_ready,
  input logic              ent_fault,
  input logic              gen_en,
  input logic              cfg_lock,
  input logic              seed_err,
  input logic              seed_latch,
  input logic              cond_busy,
  input logic [DIV_W-1:0]  div_exp,
  input logic [18:0]       cfg_vec
);
  logic             acc;
  logic [15:0]      gap;
  logic             seen;
  logic [DIV_W-1:0] div_d;

  assign acc = ent_valid & ent_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      seen  <= 1'b0;
      div_d <= '0;
    end else begin
      div_d <= div_exp;
      if (acc) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
      if (div_exp != div_d) seen <= 1'b0;
    end
  end

  p_ready_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> (gen_en && !seed_err && !cond_busy));

  p_fault_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_fault && gen_en && !cond_busy) |=> (seed_err && seed_latch));

  p_late_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(8) && seed_err) |-> (bus_rdata == 32'd0));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> cfg_lock);

  p_cfg_only_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_vec) |-> $past(bus_en && bus_we && bus_addr == ADDR_W'(0) &&
                                bus_wdata[30] && !cfg_lock));

  p_noise_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(12)) |-> (bus_rdata[31:18] == 14'd0));

  p_pace_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen && div_exp == div_d) |-> ((32'(gap) + 32'd1) >= (32'd1 << div_exp)));
endmodule

bind entropy_csr entropy_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ent_valid (ent_valid),
  .ent_ready (ent_ready),
  .ent_fault (ent_fault),
  .gen_en    (en_q),
  .cfg_lock  (lock_q),
  .seed_err  (seed_err),
  .seed_latch(sei_q),
  .cond_busy (cond_busy),
  .div_exp   (div_q),
  .cfg_vec   ({ced_q, div_q, cfg_lo_q, cfg_hi_q})
);

// File: tb/test_entropy_csr.sv
module test_entropy_csr;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int RST_C = 16;
  localparam int REC_C = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_valid = 1'b0, ent_ready;
  logic [31:0] ent_data = '0;
  logic        ent_fault = 1'b0, clk_slow = 1'b0, auto_recover = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  entropy_csr i_entropy_csr (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_data(ent_data),
    .ent_fault(ent_fault), .clk_slow(clk_slow), .auto_recover(auto_recover)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input logic en, input logic ced,
                                     input logic [3:0] dv, input logic [7:0] lo,
                                     input logic [5:0] hi);
    return (32'(hi) << 20) | (32'(dv) << 16) | (32'(lo) << 8) |
           (32'(ced) << 5) | (32'(en) << 2);
  endfunction

  localparam logic [31:0] COND = 32'h4000_0000;
  localparam logic [31:0] LOCK = 32'h8000_0000;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] w, output int at);
    logic acc;
    at = -1;
    @(negedge clk);
    ent_valid = 1'b1; ent_data = w;
    for (int g = 0; g < 400; g++) begin
      #1 acc = ent_ready;
      if (acc) at = cyc;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    #1 ent_valid = 1'b0;
  endtask

  task automatic fault_pulse();
    @(negedge clk);
    ent_fault = 1'b1;
    @(posedge clk);
    #1 ent_fault = 1'b0;
  endtask

  task automatic cond_cycle(input logic [31:0] cfgw, input logic [31:0] nz,
                            input logic [31:0] ht, output int ones);
    logic [31:0] d;
    wr(5'h00, cfgw | COND);
    wr(5'h0C, nz);
    wr(5'h10, ht);
    wr(5'h00, cfgw & ~COND);
    ones = 0;
    for (int k = 0; k < 200; k++) begin
      rd(5'h00, d);
      if (d[30]) ones++;
      else break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, cfg0;
    int ones, tmp;
    int at[4];

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), d);
      chk("R1 reset read", d, 32'h0);
    end
    #1 chk("R1 ready low", 32'(ent_ready), 32'h0);

    // R2 unmapped offsets
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d);  chk("R2 unmapped read", d, 32'h0);
    rd(5'h1C, d);  chk("R2 unmapped read", d, 32'h0);
    rd(5'h00, d);  chk("R2 unmapped write no effect", d, 32'h0);

    // R3 plain control write: only enable sticks
    wr(5'h00, 32'h3FFF_FFFF);
    rd(5'h00, d);  chk("R3 config ignored without cond", d, 32'h4);
    wr(5'h00, 32'h0);

    // sweep over divider exponent
    for (int n = 0; n < 4; n++) begin
      cfg0 = mk(1'b1, 1'b1, 4'(n), 8'hA5, 6'h2D);
      wr(5'h00, cfg0 | COND);
      rd(5'h00, d);  chk("R3 config loaded with cond", d, cfg0 | COND);
      wr(5'h0C, 32'hFFFF_FFFF);
      rd(5'h0C, d);  chk("R6 noise width", d, 32'h0003_FFFF);
      wr(5'h10, 32'h5A5A_0000 + 32'(n));
      rd(5'h10, d);  chk("R4 health write in cond", d, 32'h5A5A_0000 + 32'(n));
      wr(5'h00, cfg0);
      ones = 0;
      for (int k = 0; k < 200; k++) begin
        rd(5'h00, d);
        if (d[30]) ones++;
        else break;
      end
      chk("R4 cond busy length", 32'(ones), 32'(RST_C));
      chk("R4 control after release", d, cfg0);
      wr(5'h00, mk(1'b1, 1'b0, 4'(n ^ 1), 8'h00, 6'h00));
      rd(5'h00, d);  chk("R3 config unchanged", d, cfg0);
      wr(5'h0C, 32'h111);
      rd(5'h0C, d);  chk("R4 noise locked outside cond", d, 32'h0003_FFFF);

      for (int i = 0; i < 4; i++) push(32'hC0DE_0000 + 32'(n * 16 + i), at[i]);
      for (int i = 1; i < 4; i++)
        chk("R8 pace gap", 32'(at[i] - at[i-1]), 32'd1 << n);
      @(negedge clk);
      ent_valid = 1'b1;
      #1 chk("R7 ready low when full", 32'(ent_ready), 32'h0);
      ent_valid = 1'b0;
      rd(5'h04, d);  chk("R9 data ready set", d, 32'h1);
      for (int i = 0; i < 4; i++) begin
        rd(5'h08, d);
        chk("R9 order", d, 32'hC0DE_0000 + 32'(n * 16 + i));
      end
      rd(5'h04, d);  chk("R9 data ready clear", d, 32'h0);
    end

    // same-cycle pop and push
    cfg0 = mk(1'b1, 1'b1, 4'd0, 8'hA5, 6'h2D);
    cond_cycle(cfg0, 32'h0F0F0, 32'h77, ones);
    push(32'hAAAA_0001, tmp);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 5'h08;
    ent_valid = 1'b1; ent_data = 32'hAAAA_0002;
    #1 d = bus_rdata;
    chk("R7 ready with room", 32'(ent_ready), 32'h1);
    @(posedge clk);
    #1 bus_en = 1'b0; ent_valid = 1'b0;
    chk("R9 pop returns older", d, 32'hAAAA_0001);
    rd(5'h04, d);  chk("R9 one word left", d, 32'h1);
    rd(5'h08, d);  chk("R9 newer word", d, 32'hAAAA_0002);

    // R10 / R11 manual recovery
    auto_recover = 1'b0;
    push(32'h1111, tmp);
    push(32'h2222, tmp);
    fault_pulse();
    rd(5'h04, d);  chk("R10 fault flags", d, 32'h45);
    @(negedge clk);
    ent_valid = 1'b1;
    #1 chk("R10 ready low on error", 32'(ent_ready), 32'h0);
    ent_valid = 1'b0;
    rd(5'h08, d);  chk("R10 late error reads zero", d, 32'h0);
    repeat (30) @(posedge clk);
    rd(5'h04, d);  chk("R11 manual error persists", d, 32'h45);
    wr(5'h04, 32'h0);
    rd(5'h04, d);  chk("R12 latched seed cleared", d, 32'h05);
    cond_cycle(cfg0, 32'h0F0F0, 32'h77, ones);
    chk("R4 cond busy length", 32'(ones), 32'(RST_C));
    rd(5'h04, d);  chk("R4 cond clears error and flushes", d, 32'h0);
    push(32'h3333, tmp);
    rd(5'h08, d);  chk("R9 data after recovery", d, 32'h3333);

    // R11 auto recovery
    auto_recover = 1'b1;
    push(32'h4444, tmp);
    fault_pulse();
    rd(5'h04, d);  chk("R10 fault flags auto", d, 32'h45);
    repeat (REC_C + 2) @(posedge clk);
    rd(5'h04, d);  chk("R11 auto clears current only", d, 32'h40);
    wr(5'h04, 32'h40);
    rd(5'h04, d);  chk("R12 write one keeps", d, 32'h40);
    wr(5'h04, 32'hFFFF_FFBF);
    rd(5'h04, d);  chk("R12 write zero clears", d, 32'h0);
    auto_recover = 1'b0;

    // R13 clock error
    @(negedge clk) clk_slow = 1'b1;
    rd(5'h04, d);  chk("R13 clock error", d, 32'h22);
    @(negedge clk) clk_slow = 1'b0;
    rd(5'h04, d);  chk("R13 clock error latched", d, 32'h20);
    wr(5'h04, 32'h0);
    rd(5'h04, d);  chk("R12 clock latch cleared", d, 32'h0);
    cond_cycle(mk(1'b1, 1'b0, 4'd0, 8'hA5, 6'h2D), 32'h0F0F0, 32'h77, ones);
    @(negedge clk) clk_slow = 1'b1;
    rd(5'h04, d);  chk("R13 detect off", d, 32'h0);
    @(negedge clk) clk_slow = 1'b0;

    // R7 / R10 disabled
    wr(5'h00, 32'h0);
    @(negedge clk);
    ent_valid = 1'b1;
    #1 chk("R7 ready low when disabled", 32'(ent_ready), 32'h0);
    ent_valid = 1'b0;
    fault_pulse();
    rd(5'h04, d);  chk("R10 fault ignored when disabled", d, 32'h0);

    // R5 lock
    cfg0 = mk(1'b1, 1'b1, 4'd2, 8'h3C, 6'h11) | LOCK;
    wr(5'h00, cfg0 | COND);
    rd(5'h00, d);  chk("R5 lock with config", d, cfg0 | COND);
    wr(5'h0C, 32'h1234);
    rd(5'h0C, d);  chk("R5 noise locked", d, 32'h0F0F0);
    wr(5'h00, cfg0);
    repeat (RST_C + 2) @(posedge clk);
    wr(5'h00, mk(1'b1, 1'b0, 4'd0, 8'h00, 6'h00) | COND);
    rd(5'h00, d);  chk("R5 config locked", d, cfg0 | COND);
    wr(5'h00, 32'h4);
    repeat (RST_C + 2) @(posedge clk);
    rd(5'h00, d);  chk("R5 lock sticky", d, cfg0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule